// File: doc/BRIEF.md
# Converter Serial Result and Configuration Port

This block is the digital serial port of a 16-bit sampling converter. Each time the converter finishes, it pulses a conversion-done strobe with the parallel result. The port then holds a 24-bit readout frame: the result, formatted to match the active input range, followed by a start-of-sequence marker and the 7 configuration bits that were in force for that conversion. A host shifts the frame out on SDO with a serial clock while the active-low read enable is low. On the same rising clock edges, the host shifts a new 8-bit control word in on SDI.

A received control word selects the input channel, the input range and the gain-compression option. It waits until the next conversion-done strobe before it becomes active, so it governs the following conversion. The serial clock, read enable and data lines are assumed to be synchronous to the block clock. Rising edges of the serial clock are detected by sampling it with `clk`. The result input is a plain strobe rather than a valid/ready stream, because the converter cannot be stalled. The block accepts every strobe at once, so there is no back-pressure: a strobe always overwrites the held frame.

Top module: `adc_serial_port`

## Requirements
- R1: After reset, `sdo` is 0 and `sdo_oe` is 0 while `rd_n` is high. All configuration outputs are 0: channel 0, range 00, gain compression off and sequencer flag 0.
- R2: `sdo_oe` equals the inverse of `rd_n`. Serial-clock edges while `rd_n` is high change neither the readout position nor the received control word.
- R3: After a conversion-done strobe, result bit 15 is on `sdo` before the first serial-clock rising edge. Each rising edge then moves `sdo` to the next frame bit.
- R4: The frame order is as follows. First come the 16 result bits, MSB first. Next is the start-of-sequence input sampled at the strobe. Last are 7 configuration bits in the order channel[3:0], range[1:0], gain compression. These bits are the configuration that was active for that conversion.
- R5: Once 24 rising edges have occurred in a frame, `sdo` stays 0 until a conversion-done strobe or a falling edge of `rd_n`.
- R6: The control word is received MSB first. Bit 7 is the sequencer flag, bits 6:3 the channel, bits 2:1 the range and bit 0 the gain-compression enable.
- R7: A complete control word becomes active only at the next conversion-done strobe. The frame loaded at that strobe still reports the previous configuration.
- R8: A control word with fewer than 8 bits received before a strobe or a read-enable falling edge is discarded, and the active configuration is kept.
- R9: Gain compression reads 0 whenever the range is 00, regardless of control bit 0. This applies to both the output pin and the frame.
- R10: When range bit 0 is 1 (ranges 01 and 11, two's complement), the result MSB is inverted before it enters the frame. Ranges 00 and 10 pass the result unchanged.
- R11: A falling edge of `rd_n` restarts the readout at result bit 15 of the held frame.
- R12: Serial-clock edges beyond the 8th in a frame do not alter the received control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| rd_n | input | 1 | Active-low serial read enable |
| sck | input | 1 | Serial clock, sampled by `clk` |
| sdi | input | 1 | Serial control-word input |
| sdo | output | 1 | Serial frame output |
| sdo_oe | output | 1 | Drive enable for `sdo` |
| conv_done | input | 1 | One-cycle conversion-done strobe |
| result_in | input | 16 | Raw offset-binary conversion result |
| sos_in | input | 1 | Start-of-sequence flag for this result |
| cfg_chan | output | 4 | Active channel select |
| cfg_range | output | 2 | Active range select |
| cfg_gcomp | output | 1 | Active gain-compression enable |
| cfg_seq | output | 1 | Active sequencer flag |

## Verification
The embedded properties hold on every cycle for four behaviours:
- The active configuration moves only on a strobe.
- Gain compression is never reported with range 00.
- The frame position saturates at 24, with `sdo` at 0 beyond it.
- The output bit stays frozen while reading is disabled.

Other behaviours need multi-cycle scenarios from the bench: frame ordering, the one-conversion delay of a new word, discarding a partial word, the restart on a read-enable falling edge, and MSB inversion under each range. In these scenarios a scoreboard compares every shifted bit with a frame built from the requirements.

// File: rtl/adc_sp_pkg.sv
package adc_sp_pkg;
  typedef enum logic [1:0] {
    RNG_PSEUDO_UNI = 2'b00,
    RNG_PSEUDO_BIP = 2'b01,
    RNG_DIFF_UNI   = 2'b10,
    RNG_DIFF_BIP   = 2'b11
  } range_e;

  // A range code with bit 0 set uses two's-complement output.
  function automatic logic range_is_twos(input logic [1:0] rng);
    return rng[0];
  endfunction
endpackage

// File: rtl/adc_sp_ctl_rx.sv
module adc_sp_ctl_rx #(
  parameter int CHAN_W = 4,
  localparam int CTL_W = CHAN_W + 4,
  localparam int CNT_W = $clog2(CTL_W + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sdi,
  input  logic             frame_rst,
  input  logic             conv_done,
  output logic [CTL_W-1:0] act_word
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CTL_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CTL_W - 1);

  logic [CTL_W-1:0] sr_q, pend_q, next_sr;
  logic [CNT_W-1:0] cnt_q;
  logic             pend_v_q;

  assign next_sr = {sr_q[CTL_W-2:0], sdi};

  function automatic logic [CTL_W-1:0] force_gc(input logic [CTL_W-1:0] w);
    logic [CTL_W-1:0] r;
    r    = w;
    r[0] = w[0] & (w[2:1] != 2'b00);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q     <= '0;
      cnt_q    <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      act_word <= '0;
    end else begin
      if (frame_rst) begin
        cnt_q <= '0;
        if (conv_done && pend_v_q) begin
          act_word <= force_gc(pend_q);
          pend_v_q <= 1'b0;
        end
      end else if (shift_en && cnt_q < FULL) begin
        sr_q  <= next_sr;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          pend_q   <= next_sr;
          pend_v_q <= 1'b1;
        end
      end
    end
  end

  // R7
  act_only_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(conv_done) |-> $stable(act_word));

  // R9
  no_gcomp_unipolar_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_word[2:1] == 2'b00) |-> !act_word[0]);
endmodule

// File: rtl/adc_sp_frame_tx.sv
module adc_sp_frame_tx #(
  parameter int FRAME_W = 24,
  localparam int CNT_W = $clog2(FRAME_W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic               restart,
  input  logic               adv,
  output logic               bit_out
);
  localparam logic [CNT_W-1:0] END_POS = CNT_W'(FRAME_W);

  logic [FRAME_W-1:0] frame_q, shifted;
  logic [CNT_W-1:0]   pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      pos_q   <= END_POS;
    end else if (load) begin
      frame_q <= frame_in;
      pos_q   <= '0;
    end else if (restart) begin
      pos_q <= '0;
    end else if (adv && pos_q < END_POS) begin
      pos_q <= pos_q + 1'b1;
    end
  end

  assign shifted = frame_q << pos_q;
  assign bit_out = (pos_q < END_POS) & shifted[FRAME_W-1];

  // R5
  pos_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pos_q <= END_POS);

  // R5
  tail_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_q == END_POS) |-> !bit_out);
endmodule

// File: rtl/adc_serial_port.sv
module adc_serial_port #(
  parameter int RES_W  = 16,
  parameter int CHAN_W = 4,
  localparam int CTL_W   = CHAN_W + 4,
  localparam int FRAME_W = RES_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n,
  input  logic              sck,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  result_in,
  input  logic              sos_in,
  output logic [CHAN_W-1:0] cfg_chan,
  output logic [1:0]        cfg_range,
  output logic              cfg_gcomp,
  output logic              cfg_seq
);
  import adc_sp_pkg::*;

  logic               sck_q, rd_q;
  logic               sck_rise, rd_fall, frame_rst;
  logic [CTL_W-1:0]   act;
  logic [RES_W-1:0]   fmt_res;
  logic [FRAME_W-1:0] frame_d;
  logic               tx_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      rd_q  <= 1'b1;
    end else begin
      sck_q <= sck;
      rd_q  <= rd_n;
    end
  end

  assign sck_rise  = sck & ~sck_q & ~rd_n;
  assign rd_fall   = ~rd_n & rd_q;
  assign frame_rst = conv_done | rd_fall;

  adc_sp_ctl_rx #(.CHAN_W(CHAN_W)) u_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (sck_rise),
    .sdi       (sdi),
    .frame_rst (frame_rst),
    .conv_done (conv_done),
    .act_word  (act)
  );

  // Output-code formatter follows the range active for this conversion.
  always_comb begin
    fmt_res = result_in;
    if (range_is_twos(act[2:1])) fmt_res[RES_W-1] = ~result_in[RES_W-1];
  end

  assign frame_d = {fmt_res, sos_in, act[CTL_W-2:0]};

  adc_sp_frame_tx #(.FRAME_W(FRAME_W)) u_tx (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (conv_done),
    .frame_in (frame_d),
    .restart  (rd_fall),
    .adv      (sck_rise),
    .bit_out  (tx_bit)
  );

  assign sdo_oe    = ~rd_n;
  assign sdo       = tx_bit & ~rd_n;
  assign cfg_seq   = act[CTL_W-1];
  assign cfg_chan  = act[CTL_W-2:3];
  assign cfg_range = act[2:1];
  assign cfg_gcomp = act[0];

  // R2
  idle_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_n) && !$past(conv_done)) |-> $stable(tx_bit));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> (!sdo && !sdo_oe));
endmodule

// File: tb/adc_serial_port_test.sv
module adc_serial_port_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_n = 1'b1, sck = 1'b0, sdi = 1'b0, conv_done = 1'b0, sos_in = 1'b0;
  logic [15:0] result_in = '0;
  logic sdo, sdo_oe, cfg_gcomp, cfg_seq;
  logic [3:0] cfg_chan;
  logic [1:0] cfg_range;

  int checks = 0, fails = 0;

  typedef struct { logic b; string tag; } exp_t;
  exp_t exp_q[$];
  event smp;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_port uut (
    .clk(clk), .rst_n(rst_n), .rd_n(rd_n), .sck(sck), .sdi(sdi),
    .sdo(sdo), .sdo_oe(sdo_oe), .conv_done(conv_done),
    .result_in(result_in), .sos_in(sos_in), .cfg_chan(cfg_chan),
    .cfg_range(cfg_range), .cfg_gcomp(cfg_gcomp), .cfg_seq(cfg_seq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // Model of the frame taken from the requirements.
  function automatic logic [23:0] model_frame(input logic [15:0] r, input logic s,
                                              input logic [7:0] w);
    logic gc;
    logic [15:0] f;
    gc = w[0] & (w[2:1] != 2'b00);
    f  = r;
    if (w[1]) f[15] = ~r[15];
    return {f, s, w[6:1], gc};
  endfunction

  task automatic push_frame(input logic [23:0] fr, input int tail);
    for (int i = 23; i >= 0; i--) exp_q.push_back('{fr[i], (i == 23) ? "R3" : "R4"});
    for (int i = 0; i < tail; i++) exp_q.push_back('{1'b0, "R5"});
  endtask

  // Monitor: pops one expected bit per sample request.
  always @(smp) begin
    exp_t e;
    if (exp_q.size() == 0) begin
      checks++; fails++;
      $display("FAIL R4: got %b expected no further bit", sdo);
    end else begin
      e = exp_q.pop_front();
      chk(e.tag, {31'b0, sdo}, {31'b0, e.b});
    end
  end

  task automatic sck_pulse(input logic d);
    @(negedge clk); sck = 1'b1; sdi = d;
    @(negedge clk); sck = 1'b0;
  endtask

  // Shift n bits: sample sdo before each rising edge, send word then junk.
  task automatic read_bits(input int n, input logic [7:0] w, input logic junk);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); -> smp; #1;
      sck = 1'b1; sdi = (i < 8) ? w[7-i] : junk;
      @(negedge clk); sck = 1'b0;
    end
  endtask

  task automatic strobe(input logic [15:0] r, input logic s);
    @(negedge clk); conv_done = 1'b1; result_in = r; sos_in = s;
    @(negedge clk); conv_done = 1'b0;
  endtask

  task automatic chk_cfg(input string tag, input logic [7:0] w);
    chk({tag, " seq"},   {31'b0, cfg_seq},   {31'b0, w[7]});
    chk({tag, " chan"},  {28'b0, cfg_chan},  {28'b0, w[6:3]});
    chk({tag, " range"}, {30'b0, cfg_range}, {30'b0, w[2:1]});
    chk({tag, " gcomp"}, {31'b0, cfg_gcomp}, {31'b0, w[0] & (w[2:1] != 2'b00)});
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 sdo", {31'b0, sdo}, 0);
    chk("R1 sdo_oe", {31'b0, sdo_oe}, 0);
    chk_cfg("R1", 8'h00);

    @(negedge clk); rd_n = 1'b0; @(negedge clk);
    chk("R2 oe low rd", {31'b0, sdo_oe}, 1);

    // Frame 1 under reset config; send word 0xAB (R6).
    strobe(16'h8001, 1'b1);
    push_frame(model_frame(16'h8001, 1'b1, 8'h00), 2);
    read_bits(26, 8'hAB, 1'b0);
    chk_cfg("R7 pending not yet active", 8'h00);

    // Frame 2 still reports the old config (R7); partial word follows.
    strobe(16'h1234, 1'b0);
    chk_cfg("R6 word fields", 8'hAB);
    push_frame(model_frame(16'h1234, 1'b0, 8'h00), 0);
    read_bits(5, 8'h00, 1'b0);
    exp_q.delete();

    // Frame 3: two's complement range 01 (R10); partial discarded (R8).
    strobe(16'h1234, 1'b1);
    chk_cfg("R8 partial discarded", 8'hAB);
    push_frame(model_frame(16'h1234, 1'b1, 8'hAB), 0);
    read_bits(10, 8'h19, 1'b1);      // R12 extra bits are 1s
    exp_q.delete();
    @(negedge clk); rd_n = 1'b1;
    @(negedge clk);
    chk("R2 oe off", {31'b0, sdo_oe}, 0);
    sck_pulse(1'b0); sck_pulse(1'b0);
    @(negedge clk); rd_n = 1'b0; @(negedge clk);
    // R11 restart from bit 15
    push_frame(model_frame(16'h1234, 1'b1, 8'hAB), 1);
    read_bits(25, 8'h19, 1'b1);

    // Frame 4: config 0x19 active, gcomp forced off (R9).
    strobe(16'hFFFF, 1'b0);
    chk_cfg("R9 forced off", 8'h19);
    chk("R9 gcomp pin", {31'b0, cfg_gcomp}, 0);
    chk("R12 extra bits ignored chan", {28'b0, cfg_chan}, 4'h3);
    push_frame(model_frame(16'hFFFF, 1'b0, 8'hAB), 0);
    read_bits(24, 8'h16, 1'b0);

    // Serial edges with rd_n high must not change the pending word (R2).
    @(negedge clk); rd_n = 1'b1;
    for (int i = 0; i < 8; i++) sck_pulse(1'b1);
    strobe(16'h0000, 1'b1);
    chk_cfg("R2 idle edges ignored", 8'h16);
    @(negedge clk); rd_n = 1'b0; @(negedge clk);
    push_frame(model_frame(16'h0000, 1'b1, 8'h19), 0);
    read_bits(24, 8'h00, 1'b0);

    // Frame 6: range 11 inverts MSB (R10).
    strobe(16'h0001, 1'b0);
    push_frame(model_frame(16'h0001, 1'b0, 8'h16), 1);
    read_bits(25, 8'h00, 1'b0);
    chk("R10 queue drained", exp_q.size(), 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule